// File: doc/BRIEF.md
# Infrared Pulse Codec Line Switch

This block sits between a UART's serial pins and the outside world. When the infrared mode is off, it passes the wired transmit line, the wired receive line and the modem status lines straight through, and the infrared LED output stays dark. When the infrared mode is on, it takes over both directions of the UART:

- **Transmit side.** Every zero bit the UART sends becomes a short light pulse on the LED driver output.
- **Receive side.** Pulses arriving from the photodiode input become zero bits on the UART's receive line.
- **Wired port.** The wired transmit pin is parked at its idle level. The wired receive input and the modem status inputs are masked, so the UART does not see them.

Timing comes from a single-cycle tick input at sixteen times the bit rate, the same tick the UART uses for oversampling. The encoder assumes that the UART changes its transmit line only in the clock just after a tick, and holds each bit for a whole bit period. The decoder stretches each detected pulse into a low level that lasts a little more than one bit period, so the UART's mid-bit sample reads a zero.

Top module: `ir_sir_bridge`

## Requirements
- R1: After reset with the infrared mode off, `led_out` is low and `uart_rxd` follows `wire_rxd`.
- R2: While the mode is on, a zero bit on `uart_txd` drives `led_out` high on the first tick edge of the bit. It stays high for exactly PULSE_TICKS tick periods (3 of 16). Each bit of a run of zeros produces its own pulse.
- R3: While the mode is on, a one bit on `uart_txd` produces no pulse: `led_out` stays low for the whole bit.
- R4: While the mode is on, `wire_txd` is held high (idle), whatever `uart_txd` does.
- R5: While the mode is on, a rising edge on `pd_in` drives `uart_rxd` low for BIT_TICKS+1 ticks, counted from when the edge passes a two-stage synchronizer. At the bit's mid-point (tick 8 of 16), `uart_rxd` is 0 for a bit that carried a pulse and 1 for a bit without one.
- R6: While the mode is on, `wire_rxd` and `wire_modem` have no effect. `modem_to_uart` reads all ones, which is the inactive level of the active-low status lines.
- R7: While the mode is off, `led_out` is low, `wire_txd` equals `uart_txd`, `uart_rxd` equals `wire_rxd`, and `modem_to_uart` equals `wire_modem`.
- R8: While the mode is off, pulses on `pd_in` have no effect on `uart_rxd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_en | input | 1 | Selects the infrared path when high |
| baud_tick16 | input | 1 | One-cycle tick at 16x the bit rate |
| uart_txd | input | 1 | NRZ transmit data from the UART |
| uart_rxd | output | 1 | NRZ receive data to the UART |
| modem_to_uart | output | MODEM_W | Modem status lines to the UART (active low) |
| wire_txd | output | 1 | Wired transmit pin |
| wire_rxd | input | 1 | Wired receive pin |
| wire_modem | input | MODEM_W | Wired modem status pins (active low) |
| led_out | output | 1 | Infrared LED driver |
| pd_in | input | 1 | Photodiode receiver input |

## Verification
The encoder checks assume that `uart_txd` changes only in the clock that follows a tick, and that each bit lasts a whole multiple of sixteen ticks. The decoder checks assume that each photodiode pulse is wider than two clocks and that its rising edge falls near the start of a bit. The stimulus meets both assumptions by construction:

- The bench generates the tick itself, once every four clocks.
- It changes `uart_txd` and `pd_in` only right after a tick edge.
- It sends whole frames whose pulses last three ticks.

While the infrared mode is on, the wired inputs are toggled on every clock. This shows that they are ignored.

// File: rtl/sir_pkg.sv
package sir_pkg;
    parameter int unsigned SIR_BIT_TICKS   = 16;
    parameter int unsigned SIR_PULSE_TICKS = 3;
    parameter int unsigned SIR_MODEM_W     = 3;

    typedef enum logic {
        PATH_WIRED = 1'b0,
        PATH_IR    = 1'b1
    } path_sel_e;
endpackage

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc #(
    parameter int unsigned BIT_TICKS   = 16,
    parameter int unsigned PULSE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic txd,
    output logic led
);
    localparam int unsigned CW = $clog2(BIT_TICKS);
    localparam logic [CW-1:0] LAST_PH  = CW'(BIT_TICKS - 1);
    localparam logic [CW-1:0] PULSE_PH = CW'(PULSE_TICKS);

    typedef struct packed {
        logic [CW-1:0] ph;
        logic          prev;
        logic          led;
    } enc_st_t;

    enc_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d.ph   = '0;
            st_d.prev = 1'b1;
            st_d.led  = 1'b0;
        end else if (tick) begin
            if (txd) begin
                st_d.ph  = '0;
                st_d.led = 1'b0;
            end else begin
                if (st_q.prev || st_q.ph == LAST_PH) begin
                    st_d.ph = '0;
                end else begin
                    st_d.ph = st_q.ph + 1'b1;
                end
                st_d.led = (st_d.ph < PULSE_PH);
            end
            st_d.prev = txd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: '0, prev: 1'b1, led: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign led = st_q.led;
endmodule

// File: rtl/sir_pulse_dec.sv
module sir_pulse_dec #(
    parameter int unsigned BIT_TICKS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic pd,
    output logic rxd
);
    localparam int unsigned HOLD = BIT_TICKS + 1;
    localparam int unsigned CW   = $clog2(HOLD + 1);

    typedef struct packed {
        logic          s1;
        logic          s2;
        logic          s3;
        logic [CW-1:0] cnt;
    } dec_st_t;

    dec_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pd;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        if (!en) begin
            st_d.cnt = '0;
        end else if (st_q.s2 && !st_q.s3) begin
            st_d.cnt = CW'(HOLD);
        end else if (tick && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rxd = (st_q.cnt == '0);
endmodule

// File: rtl/sir_line_mux.sv
module sir_line_mux
    import sir_pkg::*;
#(
    parameter int unsigned MODEM_W = 3
) (
    input  path_sel_e          sel,
    input  logic               uart_txd,
    input  logic               ir_rxd,
    input  logic               wire_rxd,
    input  logic [MODEM_W-1:0] wire_modem,
    output logic               wire_txd,
    output logic               uart_rxd,
    output logic [MODEM_W-1:0] modem_to_uart
);
    always_comb begin
        if (sel == PATH_IR) begin
            wire_txd      = 1'b1;
            uart_rxd      = ir_rxd;
            modem_to_uart = '1;
        end else begin
            wire_txd      = uart_txd;
            uart_rxd      = wire_rxd;
            modem_to_uart = wire_modem;
        end
    end
endmodule

// File: rtl/ir_sir_bridge.sv
module ir_sir_bridge
    import sir_pkg::*;
#(
    parameter int unsigned BIT_TICKS   = SIR_BIT_TICKS,
    parameter int unsigned PULSE_TICKS = SIR_PULSE_TICKS,
    parameter int unsigned MODEM_W     = SIR_MODEM_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ir_en,
    input  logic               baud_tick16,
    input  logic               uart_txd,
    output logic               uart_rxd,
    output logic [MODEM_W-1:0] modem_to_uart,
    output logic               wire_txd,
    input  logic               wire_rxd,
    input  logic [MODEM_W-1:0] wire_modem,
    output logic               led_out,
    input  logic               pd_in
);
    path_sel_e sel;
    logic      ir_rxd;

    assign sel = ir_en ? PATH_IR : PATH_WIRED;

    sir_pulse_enc #(.BIT_TICKS(BIT_TICKS), .PULSE_TICKS(PULSE_TICKS)) enc_i (
        .clk(clk), .rst_n(rst_n), .en(ir_en), .tick(baud_tick16),
        .txd(uart_txd), .led(led_out)
    );

    sir_pulse_dec #(.BIT_TICKS(BIT_TICKS)) dec_i (
        .clk(clk), .rst_n(rst_n), .en(ir_en), .tick(baud_tick16),
        .pd(pd_in), .rxd(ir_rxd)
    );

    sir_line_mux #(.MODEM_W(MODEM_W)) mux_i (
        .sel(sel), .uart_txd(uart_txd), .ir_rxd(ir_rxd),
        .wire_rxd(wire_rxd), .wire_modem(wire_modem),
        .wire_txd(wire_txd), .uart_rxd(uart_rxd),
        .modem_to_uart(modem_to_uart)
    );
endmodule

// File: rtl/ir_sir_bridge_chk.sv
module ir_sir_bridge_chk #(
    parameter int unsigned PULSE_TICKS = 3,
    parameter int unsigned MODEM_W     = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               ir_en,
    input logic               baud_tick16,
    input logic               uart_txd,
    input logic               uart_rxd,
    input logic [MODEM_W-1:0] modem_to_uart,
    input logic               wire_txd,
    input logic               wire_rxd,
    input logic [MODEM_W-1:0] wire_modem,
    input logic               led_out
);
    logic [7:0] hi_ticks_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_ticks_q <= '0;
        end else if (baud_tick16) begin
            hi_ticks_q <= led_out ? hi_ticks_q + 1'b1 : '0;
        end
    end

    p_pulse_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_ticks_q <= 8'(PULSE_TICKS));

    p_no_pulse_on_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(led_out) |-> (!$past(uart_txd) && $past(baud_tick16)));

    p_wire_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ir_en |-> wire_txd);

    p_modem_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ir_en |-> (&modem_to_uart));

    p_led_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_en |=> !led_out);

    p_rx_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_en |-> (uart_rxd == wire_rxd && modem_to_uart == wire_modem));
endmodule

bind ir_sir_bridge ir_sir_bridge_chk #(.PULSE_TICKS(PULSE_TICKS), .MODEM_W(MODEM_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .ir_en(ir_en), .baud_tick16(baud_tick16),
    .uart_txd(uart_txd), .uart_rxd(uart_rxd), .modem_to_uart(modem_to_uart),
    .wire_txd(wire_txd), .wire_rxd(wire_rxd), .wire_modem(wire_modem),
    .led_out(led_out)
);

// File: tb/ir_sir_bridge_tb_top.sv
module ir_sir_bridge_tb_top;
    localparam int BT = 16;
    localparam int PT = 3;
    localparam int MW = 3;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ir_en = 1'b0;
    logic baud_tick16 = 1'b0;
    logic uart_txd = 1'b1;
    logic uart_rxd;
    logic [MW-1:0] modem_to_uart;
    logic wire_txd;
    logic wire_rxd = 1'b1;
    logic [MW-1:0] wire_modem = '1;
    logic led_out;
    logic pd_in = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    ir_sir_bridge #(.BIT_TICKS(BT), .PULSE_TICKS(PT), .MODEM_W(MW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ir_en(ir_en), .baud_tick16(baud_tick16),
        .uart_txd(uart_txd), .uart_rxd(uart_rxd), .modem_to_uart(modem_to_uart),
        .wire_txd(wire_txd), .wire_rxd(wire_rxd), .wire_modem(wire_modem),
        .led_out(led_out), .pd_in(pd_in)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic tk);
        baud_tick16 = tk;
        @(posedge clk);
        #1;
    endtask

    // transmit one bit and count LED-high clocks (R2, R3, R4, R7)
    task automatic tx_bit(input logic b);
        int hi = 0;
        int wbad = 0;
        uart_txd = b;
        for (int t = 0; t < BT; t++) begin
            for (int c = 0; c < DIV; c++) begin
                cyc(c == 0);
                if (led_out) hi++;
                if (wire_txd !== (ir_en ? 1'b1 : b)) wbad++;
            end
        end
        if (!ir_en) check("R7 led dark", hi, 0);
        else if (b) check("R3 one bit no pulse", hi, 0);
        else check("R2 zero bit pulse", hi, PT * DIV);
        check(ir_en ? "R4 wired tx idle" : "R7 wired tx pass", wbad, 0);
    endtask

    // receive one bit through photodiode, wired lines toggling (R5, R6, R7, R8)
    task automatic rx_bit(input logic b);
        int mbad = 0;
        int mid = -1;
        for (int t = 0; t < BT; t++) begin
            for (int c = 0; c < DIV; c++) begin
                pd_in = (!b && t < PT);
                if (ir_en) begin
                    wire_rxd = c[0];
                    wire_modem = MW'(t + c);
                end else begin
                    wire_rxd = b;
                    wire_modem = MW'(t);
                end
                cyc(c == 0);
                if (modem_to_uart !== (ir_en ? {MW{1'b1}} : wire_modem)) mbad++;
                if (t == BT / 2 && c == 0) mid = int'(uart_rxd);
            end
        end
        if (ir_en) check("R5 decoded mid-bit", mid, int'(b));
        else check("R8 pd ignored, wired rx", mid, int'(b));
        check(ir_en ? "R6 modem masked" : "R7 modem pass", mbad, 0);
    endtask

    task automatic tx_frame(input logic [7:0] v);
        tx_bit(1'b0);
        for (int i = 0; i < 8; i++) tx_bit(v[i]);
        tx_bit(1'b1);
        tx_bit(1'b1);
    endtask

    task automatic rx_frame(input logic [7:0] v);
        rx_bit(1'b0);
        for (int i = 0; i < 8; i++) rx_bit(v[i]);
        rx_bit(1'b1);
        rx_bit(1'b1);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        cyc(1'b0);
        // R1: reset state
        check("R1 led low after reset", int'(led_out), 0);
        wire_rxd = 1'b0;
        #1;
        check("R1 rx follows wire", int'(uart_rxd), 0);
        wire_rxd = 1'b1;
        #1;
        check("R1 rx follows wire high", int'(uart_rxd), 1);

        // infrared mode on
        ir_en = 1'b1;
        cyc(1'b0);
        for (int k = 0; k < 12; k++) begin
            logic [7:0] v = 8'(k * 37 + 5);
            if (k == 0) v = 8'h00;
            if (k == 1) v = 8'hFF;
            tx_frame(v);
        end
        uart_txd = 1'b1;
        cyc(1'b0);
        for (int k = 0; k < 10; k++) begin
            logic [7:0] v = 8'(k * 53 + 9);
            if (k == 0) v = 8'h00;
            if (k == 1) v = 8'hFF;
            rx_frame(v);
        end
        pd_in = 1'b0;
        repeat (BT * DIV * 2) cyc(1'b0);

        // infrared mode off
        ir_en = 1'b0;
        wire_rxd = 1'b1;
        cyc(1'b0);
        cyc(1'b0);
        tx_frame(8'h5A);
        tx_frame(8'h00);
        uart_txd = 1'b1;
        rx_frame(8'h00);
        rx_frame(8'hC3);
        pd_in = 1'b0;
        cyc(1'b0);
        finish_run();
    end
endmodule